// File: doc/BRIEF.md
# Eight-Channel DAC Register and Power Controller

This block is the digital control core behind an eight-channel digital-to-analog converter. A decoded command arrives as a one-cycle strobe carrying a 4-bit operation code, a 4-bit channel selector and a 16-bit data word. For each channel the core keeps a staging register (the input register) and an output register (the DAC register). It also tracks whether each channel is powered down, whether the on-chip reference is selected, and whether that reference is currently running. An active-low asynchronous load pin updates every channel at once.

The outputs are the DAC register values, one enable flag per channel, a reference-enable flag and a busy flag. Busy stays high while a channel that has just been woken is settling. The wake delay is a cycle count taken from a clock-frequency parameter. It is longer when the whole part was asleep: every channel down and the reference off.

The power controller is a two-state machine. In **RUN** the outputs are settled. **SETTLE** is entered when a wake occurs and counts down the delay. The transitions are: *wake* (RUN→SETTLE, counter loaded), *rewake* (SETTLE→SETTLE when another wake arrives, counter reloaded), *expire* (SETTLE→RUN when the counter reaches zero), and *hold* (otherwise).

Top module: `dac_ctrl_core`

## Requirements
- R1: Op code 0000 writes the data word into the input register of the selected channel. Selectors 0–7 pick one channel and selector 15 picks all channels. The DAC registers do not change.
- R2: Op code 0001 copies the selected input register(s) into the DAC register(s). Op code 0011 writes the data and copies it into the DAC register in the same cycle.
- R3: Op code 0010 writes the data into the selected channel and then updates every channel's DAC register.
- R4: Selectors 8–14 address no channel, and op codes 1000–1111 do nothing. Neither changes any register or flag.
- R5: Op code 0100 clears the enable flag of the selected channel(s) on the next cycle. The input and DAC registers keep their contents.
- R6: Op code 0101 clears every channel enable and the reference enable, whatever the selector. The registers keep their contents.
- R7: Op code 0110 selects the on-chip reference and turns it on. Op code 0111 selects the external reference and turns the on-chip one off, and after that only 0110 turns it back on. If the reference was turned off by 0101, any DAC update also turns it back on.
- R8: Updating a powered-down channel sets its enable on the next cycle. Busy then stays high for CLK_MHZ×WAKE_US cycles. If all eight channels were down and the reference was off before the update, busy stays high for CLK_MHZ×WAKE_CHIP_US cycles instead.
- R9: A falling edge on `load_n` passes through a two-stage synchronizer. It updates every channel's DAC register on the third rising clock edge after the low level is first sampled. Channels that were powered down wake exactly as they do for a software update of all channels.
- R10: When updates and writes fall in one cycle, the DAC register takes the input value that includes that cycle's write. If a power-down command coincides with a load strobe, the power-down wins for its channels and for the reference.
- R11: After reset both register files are zero, all channels are enabled, the on-chip reference is selected and on, and busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | 4 | Channel selector (15 = all) |
| cmd_data | input | 16 | Data word |
| load_n | input | 1 | Asynchronous active-low load-all request |
| dac_val | output | 128 | DAC registers, channel i at bits [16i+15:16i] |
| ch_en | output | 8 | Per-channel enable |
| ref_en | output | 1 | On-chip reference running |
| busy | output | 1 | Wake-up settling in progress |

## Verification
The load strobe and a software command can take effect on the same clock edge, and that is where the precedence rules decide the result. The bench drops `load_n` and then places a command on the edge where the synchronized strobe fires. It does this three times: with a channel write, with a single-channel power-down, and with a full power-down. Each outcome is compared with a reference model in the bench. Under that model a same-cycle write reaches the DAC register, and power-down overrides the wake.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [3:0] {
        OP_WRITE      = 4'b0000,
        OP_UPDATE     = 4'b0001,
        OP_WRITE_ALLU = 4'b0010,
        OP_WRITE_UPD  = 4'b0011,
        OP_SLEEP      = 4'b0100,
        OP_SLEEP_ALL  = 4'b0101,
        OP_REF_INT    = 4'b0110,
        OP_REF_EXT    = 4'b0111
    } op_e;

    typedef enum logic {
        PW_RUN,
        PW_SETTLE
    } pw_state_e;

    localparam logic [3:0] SEL_ALL = 4'hF;
endpackage

// File: rtl/dacc_load_sync.sv
module dacc_load_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    output logic strobe
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= load_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // R9: one pulse per falling edge of the synchronized pin
    assign strobe = s3 & ~s2;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/dacc_decode.sv
module dacc_decode
    import dacc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           valid,
    input  logic [3:0]     op,
    input  logic [3:0]     sel,
    output logic [NCH-1:0] wr_mask,
    output logic [NCH-1:0] upd_mask,
    output logic [NCH-1:0] pd_mask,
    output logic           pd_all,
    output logic           ref_int,
    output logic           ref_ext
);
    logic [NCH-1:0] chan;

    // R1/R4: 0..NCH-1 pick one channel, 15 picks all, the rest pick none
    always_comb begin
        chan = '0;
        for (int i = 0; i < NCH; i++)
            if (sel == 4'(i)) chan[i] = 1'b1;
        if (sel == SEL_ALL) chan = '1;
    end

    always_comb begin
        wr_mask  = '0;
        upd_mask = '0;
        pd_mask  = '0;
        pd_all   = 1'b0;
        ref_int  = 1'b0;
        ref_ext  = 1'b0;
        if (valid) begin
            unique case (op)
                OP_WRITE:      wr_mask = chan;
                OP_UPDATE:     upd_mask = chan;
                OP_WRITE_ALLU: begin wr_mask = chan; upd_mask = '1; end
                OP_WRITE_UPD:  begin wr_mask = chan; upd_mask = chan; end
                OP_SLEEP:      pd_mask = chan;
                OP_SLEEP_ALL:  pd_all = 1'b1;
                OP_REF_INT:    ref_int = 1'b1;
                OP_REF_EXT:    ref_ext = 1'b1;
                default:       ; // R4: upper op codes do nothing
            endcase
        end
    end
endmodule

// File: rtl/dacc_regbank.sv
module dacc_regbank #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    wr_mask,
    input  logic [NCH-1:0]    upd_mask,
    input  logic [DW-1:0]     data,
    output logic [NCH*DW-1:0] dac_flat
);
    logic [NCH*DW-1:0] in_flat;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] in_q, dac_q, in_next;

        // R10: an update in the same cycle sees the freshly written word
        assign in_next = wr_mask[g] ? data : in_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q  <= '0;
                dac_q <= '0;
            end else begin
                in_q <= in_next;
                if (upd_mask[g]) dac_q <= in_next;
            end
        end

        assign dac_flat[g*DW +: DW] = dac_q;
        assign in_flat[g*DW +: DW]  = in_q;
    end

    // R5/R6: without an update the DAC registers hold, whatever the power state
    a_r5_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_mask == '0) |=> $stable(dac_flat));
    a_r1_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask == '0) |=> $stable(in_flat));
endmodule

// File: rtl/dacc_power.sv
module dacc_power
    import dacc_pkg::*;
#(
    parameter int NCH          = 8,
    parameter int CLK_MHZ      = 250,
    parameter int WAKE_US      = 12,
    parameter int WAKE_CHIP_US = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] upd_mask,
    input  logic [NCH-1:0] pd_mask,
    input  logic           pd_all,
    input  logic           ref_int,
    input  logic           ref_ext,
    output logic [NCH-1:0] ch_en,
    output logic           ref_en,
    output logic           busy
);
    localparam int SHORT_CYC = CLK_MHZ * WAKE_US;
    localparam int LONG_CYC  = CLK_MHZ * WAKE_CHIP_US;
    localparam int CW        = $clog2(LONG_CYC + 1);

    pw_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [NCH-1:0] pd_q, pd_d;
    logic           sel_int_q, sel_int_d;
    logic           chip_off_q, chip_off_d;
    logic           wake, all_asleep;

    // R5/R6/R8/R10: updates wake channels, a power-down in the same cycle wins
    always_comb begin
        pd_d = (pd_q & ~upd_mask) | pd_mask | {NCH{pd_all}};
        wake = |(pd_q & ~pd_d);
        all_asleep = (&pd_q) & ~ref_en;
    end

    // R7: reference selection and the "turned off by full power-down" marker
    always_comb begin
        sel_int_d = sel_int_q;
        if (ref_int) sel_int_d = 1'b1;
        else if (ref_ext) sel_int_d = 1'b0;
        chip_off_d = chip_off_q;
        if (pd_all) chip_off_d = 1'b1;
        else if (ref_int || ref_ext || (|upd_mask)) chip_off_d = 1'b0;
    end

    // Settle timer: wake, rewake, expire, hold
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PW_RUN: begin
                if (wake) begin
                    state_d = PW_SETTLE;
                    cnt_d   = all_asleep ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
                end
            end
            PW_SETTLE: begin
                if (wake) begin
                    cnt_d = all_asleep ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
                end else if (cnt_q == '0) begin
                    state_d = PW_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PW_RUN;
            cnt_q      <= '0;
            pd_q       <= '0;
            sel_int_q  <= 1'b1;
            chip_off_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            pd_q       <= pd_d;
            sel_int_q  <= sel_int_d;
            chip_off_q <= chip_off_d;
        end
    end

    always_comb begin
        ch_en  = ~pd_q;
        ref_en = sel_int_q & ~chip_off_q;
        busy   = (state_q == PW_SETTLE);
    end

    a_r5_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mask != '0) |=> ((ch_en & $past(pd_mask)) == '0));
    a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        pd_all |=> (ch_en == '0) && !ref_en);
    a_r7_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ext |=> !ref_en);
    a_r8_wake_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> busy);
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> busy);
endmodule

// File: rtl/dac_ctrl_core.sv
module dac_ctrl_core #(
    parameter int NCH          = 8,
    parameter int DW           = 16,
    parameter int CLK_MHZ      = 250,
    parameter int WAKE_US      = 12,
    parameter int WAKE_CHIP_US = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [3:0]        cmd_sel,
    input  logic [DW-1:0]     cmd_data,
    input  logic              load_n,
    output logic [NCH*DW-1:0] dac_val,
    output logic [NCH-1:0]    ch_en,
    output logic              ref_en,
    output logic              busy
);
    logic           ld_strobe;
    logic [NCH-1:0] wr_mask, cmd_upd, upd_mask, pd_mask;
    logic           pd_all, ref_int, ref_ext;

    dacc_load_sync u_sync (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .strobe(ld_strobe)
    );

    dacc_decode #(.NCH(NCH)) u_dec (
        .valid(cmd_valid), .op(cmd_op), .sel(cmd_sel),
        .wr_mask(wr_mask), .upd_mask(cmd_upd), .pd_mask(pd_mask),
        .pd_all(pd_all), .ref_int(ref_int), .ref_ext(ref_ext)
    );

    // R9: the load strobe behaves as a software update of every channel
    assign upd_mask = cmd_upd | {NCH{ld_strobe}};

    dacc_regbank #(.NCH(NCH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .upd_mask(upd_mask),
        .data(cmd_data), .dac_flat(dac_val)
    );

    dacc_power #(
        .NCH(NCH), .CLK_MHZ(CLK_MHZ), .WAKE_US(WAKE_US), .WAKE_CHIP_US(WAKE_CHIP_US)
    ) u_pwr (
        .clk(clk), .rst_n(rst_n), .upd_mask(upd_mask), .pd_mask(pd_mask),
        .pd_all(pd_all), .ref_int(ref_int), .ref_ext(ref_ext),
        .ch_en(ch_en), .ref_en(ref_en), .busy(busy)
    );
endmodule

// File: tb/dac_ctrl_core_test.sv
`timescale 1ns/1ps
module dac_ctrl_core_test;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int SHORT_CYC = 250 * 12;
    localparam int LONG_CYC  = 250 * 14;

    typedef struct {
        string              req;
        logic [NCH*DW-1:0]  dac;
        logic [NCH-1:0]     en;
        logic               rf;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [3:0]        cmd_sel = '0;
    logic [DW-1:0]     cmd_data = '0;
    logic              load_n = 1'b1;
    logic [NCH*DW-1:0] dac_val;
    logic [NCH-1:0]    ch_en;
    logic              ref_en;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t sb[$];

    // Reference model
    logic [DW-1:0] m_in  [NCH];
    logic [DW-1:0] m_dac [NCH];
    logic [NCH-1:0] m_pd;
    logic m_sel_int, m_chip_off;
    int   m_busy;

    always #2 clk = ~clk;

    dac_ctrl_core uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .cmd_data(cmd_data), .load_n(load_n),
        .dac_val(dac_val), .ch_en(ch_en), .ref_en(ref_en), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] m_flat();
        logic [NCH*DW-1:0] f;
        for (int i = 0; i < NCH; i++) f[i*DW +: DW] = m_dac[i];
        return f;
    endfunction

    function automatic void model(input bit v, input logic [3:0] op, input logic [3:0] sel,
                                  input logic [DW-1:0] d, input bit ld);
        logic [NCH-1:0] ch, wr, up, pm, pdn;
        bit pall, ri, re, asleep, refon;
        ch = '0;
        if (sel == 4'hF) ch = '1;
        else if (sel < 4'(NCH)) ch[sel[2:0]] = 1'b1;
        wr = '0; up = '0; pm = '0; pall = 0; ri = 0; re = 0;
        if (v) begin
            case (op)
                4'b0000: wr = ch;
                4'b0001: up = ch;
                4'b0010: begin wr = ch; up = '1; end
                4'b0011: begin wr = ch; up = ch; end
                4'b0100: pm = ch;
                4'b0101: pall = 1;
                4'b0110: ri = 1;
                4'b0111: re = 1;
                default: ;
            endcase
        end
        if (ld) up = '1;
        for (int i = 0; i < NCH; i++) if (wr[i]) m_in[i] = d;
        for (int i = 0; i < NCH; i++) if (up[i]) m_dac[i] = m_in[i];
        refon  = m_sel_int && !m_chip_off;
        asleep = (&m_pd) && !refon;
        pdn = (m_pd & ~up) | pm | {NCH{pall}};
        m_busy = (|(m_pd & ~pdn)) ? (asleep ? LONG_CYC : SHORT_CYC) : 0;
        m_pd = pdn;
        if (ri) m_sel_int = 1;
        else if (re) m_sel_int = 0;
        if (pall) m_chip_off = 1;
        else if (ri || re || (|up)) m_chip_off = 0;
    endfunction

    // Driver: applies a command at a falling edge and queues the expected state
    task automatic send(input bit v, input logic [3:0] op, input logic [3:0] sel,
                        input logic [DW-1:0] d, input bit ld, input string req);
        exp_t e;
        cmd_valid = v; cmd_op = op; cmd_sel = sel; cmd_data = d;
        model(v, op, sel, d, ld);
        e.req = req; e.dac = m_flat(); e.en = ~m_pd; e.rf = m_sel_int && !m_chip_off;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Load pin aligned so its strobe meets the command on the same edge
    task automatic send_with_load(input bit v, input logic [3:0] op, input logic [3:0] sel,
                                  input logic [DW-1:0] d, input string req);
        load_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        send(v, op, sel, d, 1'b1, req);
        load_n = 1'b1;
    endtask

    task automatic check_busy(input string req);
        int n = 0;
        while (busy && n < LONG_CYC + 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == m_busy, req, n, m_busy);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops expected items just after the edge that produced them
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(dac_val == e.dac, {e.req, " dac"}, longint'(dac_val ^ e.dac), 0);
            chk(ch_en == e.en && ref_en == e.rf, {e.req, " en/ref"},
                {ch_en, ref_en}, {e.en, e.rf});
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
        m_pd = '0; m_sel_int = 1; m_chip_off = 0; m_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(dac_val == '0, "R11 dac", longint'(dac_val), 0);
        chk(ch_en == '1 && ref_en && !busy, "R11 flags", {ch_en, ref_en, busy}, 10'h3FE);

        send(1, 4'b0000, 4'd2, 16'hA5A5, 0, "R1 write one");
        send(1, 4'b0001, 4'd2, 16'h0000, 0, "R2 update one");
        send(1, 4'b0011, 4'd5, 16'h1234, 0, "R2 write+update");
        send(1, 4'b0000, 4'hF, 16'h0F0F, 0, "R1 write all");
        send(1, 4'b0010, 4'd0, 16'h7777, 0, "R3 write one update all");
        send(1, 4'b0000, 4'd9, 16'hDEAD, 0, "R4 bad selector");
        send(1, 4'b1010, 4'd3, 16'hBEEF, 0, "R4 bad op");
        send(1, 4'b0001, 4'hF, 16'h0000, 0, "R4 update after ignored");
        send(1, 4'b0100, 4'd3, 16'hFFFF, 0, "R5 sleep one");
        check_busy("R5 no busy");
        send(1, 4'b0001, 4'd3, 16'h0000, 0, "R8 wake one");
        check_busy("R8 short wake");
        send(1, 4'b0101, 4'd0, 16'h5555, 0, "R6 sleep all");
        send(1, 4'b0001, 4'd1, 16'h0000, 0, "R7 update restores ref");
        check_busy("R8 long wake");
        send(1, 4'b0111, 4'd0, 16'h0000, 0, "R7 external ref");
        send(1, 4'b0001, 4'hF, 16'h0000, 0, "R7 update keeps ref off");
        check_busy("R8 wake with ext ref");
        send(1, 4'b0110, 4'd0, 16'h0000, 0, "R7 internal ref");
        send(1, 4'b0100, 4'hF, 16'h0000, 0, "R5 sleep all channels");
        send_with_load(1, 4'b0000, 4'd4, 16'h4444, "R10 load with write");
        check_busy("R9 load wakes");
        send_with_load(1, 4'b0100, 4'd6, 16'h0000, "R10 load with sleep");
        check_busy("R10 no wake");
        send_with_load(0, 4'b0000, 4'd0, 16'h0000, "R9 load alone");
        check_busy("R9 load wake short");
        send_with_load(1, 4'b0101, 4'd0, 16'h0000, "R10 load with sleep all");
        check_busy("R10 no wake all");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9 queue drained", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule